// File: doc/BRIEF.md
# DMA Channel Event Status Bank

This block gathers the end-of-transfer and fault events of a group of DMA channels into two software-visible registers and turns them into one interrupt line per channel. The completion register holds a sticky done flag for each channel in its low half and an interrupt enable for each channel in its high half. The fault register holds a sticky fault-interrupt flag for each channel in its low half and a sticky bus-fault status bit for each channel in its high half.

Each register sits behind four word-sized write views: a plain write that replaces the value, and three views that set, clear or toggle only the bits written as one. Software acknowledges a channel by writing a one at that channel's position through the clear view, without a read-modify-write. Alongside the interrupts the block reports a two-bit fault code per channel, built from the two fault bits of that channel, with a termination that came together with a completion reported as no fault.

Top module: `dma_evt_bank`

## Requirements
- R1: After reset both registers read zero, every interrupt line is low and every fault code is 0.
- R2: A write with `wr_en` high updates the register chosen by `addr[2]` (0 = completion, 1 = fault); `addr[1:0]` chooses the view: 0 replaces the value with `wdata`, 1 ORs `wdata` in, 2 clears the bits that are one in `wdata`, 3 inverts the bits that are one in `wdata`. The other register is left alone. The new value is visible from the clock edge that takes the write.
- R3: `rdata` shows, without a clock delay, the full value of the register selected by `addr[2]`, whichever view `addr[1:0]` names.
- R4: A pulse on `evt_done[i]` sets bit i of the completion register at the next edge; hardware never changes the enable bits (positions NUM_CH+i).
- R5: A pulse on `evt_term[i]` sets bit i of the fault register; a pulse on `evt_buserr[i]` sets both bit i and bit NUM_CH+i of the fault register.
- R6: When an event and a software write to the same register arrive in one cycle, the bit the event sets ends up one, whatever the write view and data.
- R7: `irq[i]` is high exactly when completion bits i and NUM_CH+i are both one, or when fault bit i is one.
- R8: `fault_code[2i+1:2i]` is the sum of fault bits NUM_CH+i and i (0 no fault, 1 termination, 2 bus fault), except that a sum of 1 is reported as 0 while completion bit i is one; a bus fault therefore always reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_done | input | NUM_CH | Per-channel completion pulse |
| evt_term | input | NUM_CH | Per-channel termination pulse |
| evt_buserr | input | NUM_CH | Per-channel bus fault pulse |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Word address: bit 2 picks the register, bits 1:0 the write view |
| wdata | input | 2*NUM_CH | Write data |
| rdata | output | 2*NUM_CH | Read data of the addressed register |
| irq | output | NUM_CH | Per-channel interrupt line |
| fault_code | output | 2*NUM_CH | Two-bit fault code per channel |

## Verification
The bench builds the block with four channels, so each register is eight bits wide. That makes it possible to drive every start value of both registers through every write view and sixteen data patterns, and to apply all 4096 combinations of done, termination and bus-fault pulses across the four channels with a matching enable pattern, checking interrupts and fault codes for each. Collisions between events and clearing or replacing writes are swept over every event pattern.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        VIEW_REPLACE = 2'd0,
        VIEW_SET     = 2'd1,
        VIEW_CLEAR   = 2'd2,
        VIEW_TOGGLE  = 2'd3
    } wr_view_e;

    typedef enum logic {
        SEL_DONE  = 1'b0,
        SEL_FAULT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/dma_evt_view_write.sv
module dma_evt_view_write
    import dma_evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             hit,
    input  wr_view_e         view,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] nxt
);

    always_comb begin
        nxt = cur;
        if (hit) begin
            unique case (view)
                VIEW_REPLACE: nxt = wdata;
                VIEW_SET:     nxt = cur | wdata;
                VIEW_CLEAR:   nxt = cur & ~wdata;
                VIEW_TOGGLE:  nxt = cur ^ wdata;
                default:      nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/dma_evt_fault_encode.sv
module dma_evt_fault_encode #(
    parameter int NUM_CH = 16,
    localparam int REG_W = 2 * NUM_CH
) (
    input  logic [REG_W-1:0]  fault_reg,
    input  logic [NUM_CH-1:0] done_flags,
    output logic [REG_W-1:0]  code
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [1:0] raw;
        assign raw = {1'b0, fault_reg[NUM_CH+g]} + {1'b0, fault_reg[g]};
        assign code[2*g +: 2] = (raw == 2'd1 && done_flags[g]) ? 2'd0 : raw;
    end

endmodule

// File: rtl/dma_evt_irq_merge.sv
module dma_evt_irq_merge #(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CH-1:0] done_flags,
    input  logic [NUM_CH-1:0] done_enable,
    input  logic [NUM_CH-1:0] fault_flags,
    output logic [NUM_CH-1:0] irq
);

    assign irq = (done_flags & done_enable) | fault_flags;

endmodule

// File: rtl/dma_evt_bank.sv
module dma_evt_bank
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int REG_W = 2 * NUM_CH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     evt_done,
    input  logic [NUM_CH-1:0]     evt_term,
    input  logic [NUM_CH-1:0]     evt_buserr,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    output logic [NUM_CH-1:0]     irq,
    output logic [REG_W-1:0]      fault_code
);

    typedef struct packed {
        logic [REG_W-1:0] done;
        logic [REG_W-1:0] fault;
    } bank_t;

    bank_t state_d, state_q;

    reg_sel_e sel;
    wr_view_e view;
    logic [REG_W-1:0] done_sw, fault_sw;
    logic [REG_W-1:0] done_q, fault_q;

    assign sel    = reg_sel_e'(addr[2]);
    assign view   = wr_view_e'(addr[1:0]);
    assign done_q  = state_q.done;
    assign fault_q = state_q.fault;

    dma_evt_view_write #(.WIDTH(REG_W)) u_done_wr (
        .hit   (wr_en && sel == SEL_DONE),
        .view  (view),
        .cur   (state_q.done),
        .wdata (wdata),
        .nxt   (done_sw)
    );

    dma_evt_view_write #(.WIDTH(REG_W)) u_fault_wr (
        .hit   (wr_en && sel == SEL_FAULT),
        .view  (view),
        .cur   (state_q.fault),
        .wdata (wdata),
        .nxt   (fault_sw)
    );

    // Hardware events are ORed in after the software view, so they win.
    always_comb begin
        state_d       = state_q;
        state_d.done  = done_sw  | {{NUM_CH{1'b0}}, evt_done};
        state_d.fault = fault_sw | {evt_buserr, evt_term | evt_buserr};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = (sel == SEL_FAULT) ? state_q.fault : state_q.done;

    dma_evt_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
        .done_flags  (state_q.done[NUM_CH-1:0]),
        .done_enable (state_q.done[REG_W-1:NUM_CH]),
        .fault_flags (state_q.fault[NUM_CH-1:0]),
        .irq         (irq)
    );

    dma_evt_fault_encode #(.NUM_CH(NUM_CH)) u_code (
        .fault_reg  (state_q.fault),
        .done_flags (state_q.done[NUM_CH-1:0]),
        .code       (fault_code)
    );

endmodule

// File: rtl/dma_evt_bank_checker.sv
module dma_evt_bank_checker #(
    parameter int NUM_CH = 16,
    localparam int REG_W = 2 * NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] evt_done,
    input logic [NUM_CH-1:0] evt_term,
    input logic [NUM_CH-1:0] evt_buserr,
    input logic              wr_en,
    input logic [REG_W-1:0]  done_q,
    input logic [REG_W-1:0]  fault_q,
    input logic [NUM_CH-1:0] irq,
    input logic [REG_W-1:0]  fault_code
);

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_done) |=> ((done_q[NUM_CH-1:0] & $past(evt_done)) == $past(evt_done)))
        else $error("done event lost");

    assert_bus_fault_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_buserr) |=> ((fault_q[REG_W-1:NUM_CH] & $past(evt_buserr)) == $past(evt_buserr)))
        else $error("bus fault status lost");

    assert_term_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_term) |=> ((fault_q[NUM_CH-1:0] & $past(evt_term)) == $past(evt_term)))
        else $error("termination flag lost");

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && evt_done == '0 && evt_term == '0 && evt_buserr == '0)
        |=> ($stable(done_q) && $stable(fault_q)))
        else $error("register changed with no cause");

    assert_quiet_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q[NUM_CH-1:0] == '0 && fault_q[NUM_CH-1:0] == '0) |-> (irq == '0))
        else $error("interrupt with no flag");

    for (genvar g = 0; g < NUM_CH; g++) begin : g_code
        assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fault_code[2*g +: 2] != 2'b11)
            else $error("fault code 3 on channel %0d", g);

        assert_bus_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_q[NUM_CH+g] && fault_q[g]) |-> (fault_code[2*g +: 2] == 2'd2))
            else $error("bus fault not coded 2 on channel %0d", g);
    end

endmodule

bind dma_evt_bank dma_evt_bank_checker #(.NUM_CH(NUM_CH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_done   (evt_done),
    .evt_term   (evt_term),
    .evt_buserr (evt_buserr),
    .wr_en      (wr_en),
    .done_q     (done_q),
    .fault_q    (fault_q),
    .irq        (irq),
    .fault_code (fault_code)
);

// File: tb/test_dma_evt_bank.sv
`timescale 1ns/100ps
module test_dma_evt_bank;

    localparam int CH = 4;
    localparam int W  = 2 * CH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CH-1:0] evt_done = '0;
    logic [CH-1:0] evt_term = '0;
    logic [CH-1:0] evt_buserr = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic [CH-1:0] irq;
    logic [W-1:0]  fault_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    dma_evt_bank #(.NUM_CH(CH)) i_dma_evt_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_done   (evt_done),
        .evt_term   (evt_term),
        .evt_buserr (evt_buserr),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .irq        (irq),
        .fault_code (fault_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic wr(input int sel, input int view, input logic [W-1:0] d);
        addr  = 3'((sel << 2) | view);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int sel, input int view, output logic [W-1:0] v);
        addr = 3'((sel << 2) | view);
        #0.5;
        v = rdata;
    endtask

    function automatic logic [W-1:0] apply_view(input int view, input logic [W-1:0] c,
                                                 input logic [W-1:0] d);
        case (view)
            0: return d;
            1: return c | d;
            2: return c & ~d;
            default: return c ^ d;
        endcase
    endfunction

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(0, 0, v); check("R1 done reg", 32'(v), 0);
        rd(1, 0, v); check("R1 fault reg", 32'(v), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 code", 32'(fault_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: every start value through every view with sixteen data patterns
        for (int sel = 0; sel < 2; sel++) begin
            for (int view = 0; view < 4; view++) begin
                for (int s = 0; s < 256; s++) begin
                    for (int k = 0; k < 16; k++) begin
                        logic [W-1:0] d;
                        d = W'((k * 37 + 5) & 255);
                        wr(sel, 0, W'(s));
                        wr(sel, view, d);
                        rd(sel, (s + k) % 4, v);
                        check("R2 R3 view write", 32'(v), 32'(apply_view(view, W'(s), d)));
                    end
                end
            end
        end
        // R2: other register untouched
        wr(0, 0, 8'h5A);
        wr(1, 0, 8'h00);
        wr(1, 1, 8'hFF);
        rd(0, 2, v); check("R2 other register kept", 32'(v), 32'h5A);

        // R4/R5/R7/R8: all event combinations
        for (int c = 0; c < 4096; c++) begin
            logic [CH-1:0] dn, tm, bs, en, exp_irq;
            logic [W-1:0] exp_code;
            dn = CH'(c);
            tm = CH'(c >> 4);
            bs = CH'(c >> 8);
            en = ~tm ^ CH'(c >> 6);
            wr(0, 0, {en, 4'h0});
            wr(1, 0, '0);
            evt_done = dn; evt_term = tm; evt_buserr = bs;
            @(negedge clk);
            evt_done = '0; evt_term = '0; evt_buserr = '0;
            exp_irq = (dn & en) | tm | bs;
            for (int i = 0; i < CH; i++) begin
                int s, f, cd;
                s = bs[i]; f = tm[i] | bs[i]; cd = s + f;
                if (cd == 1 && dn[i]) cd = 0;
                exp_code[2*i +: 2] = 2'(cd);
            end
            rd(0, 0, v); check("R4 done reg after events", 32'(v), 32'({en, dn}));
            rd(1, 3, v); check("R5 fault reg after events", 32'(v), 32'({bs, tm | bs}));
            check("R7 irq", 32'(irq), 32'(exp_irq));
            check("R8 fault code", 32'(fault_code), 32'(exp_code));
        end

        // R6: event against a same-cycle clear of the completion register
        for (int p = 0; p < 16; p++) begin
            wr(0, 0, 8'hF0);
            wr(0, 1, 8'h0F);
            evt_done = CH'(p);
            wr(0, 2, 8'hFF);
            evt_done = '0;
            rd(0, 0, v); check("R6 done survives clear", 32'(v), 32'(p));
        end
        // R6: events against a same-cycle replace of the fault register
        for (int t = 0; t < 16; t++) begin
            for (int b = 0; b < 16; b++) begin
                wr(1, 0, 8'hFF);
                evt_term = CH'(t); evt_buserr = CH'(b);
                wr(1, 0, 8'h00);
                evt_term = '0; evt_buserr = '0;
                rd(1, 0, v); check("R6 fault survives replace", 32'(v), 32'({CH'(b), CH'(t | b)}));
            end
        end

        done_run = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_run) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule